// File: doc/BRIEF.md
# PCI Interrupt Line Router

This block collects eight shared PCI interrupt lines, numbered 0 to 7, and steers them toward two families of interrupt-controller inputs at once. Each line can be routed to one of sixteen legacy pins, where several lines may share a pin. The same line always drives its own private APIC input, whatever its legacy routing says. A power-management SCI request is merged into exactly one output, either a legacy pin or an APIC input, picked by a small control field.

Software programs the block through a byte-wide register port. The port holds one routing byte per line, the SCI control byte, and the per-slot tables that translate a device slot's four interrupt pins (INTA to INTD) into line numbers. A combinational lookup port answers "which line does slot s, pin i use". The interrupt fabric uses this answer when it wires device interrupts onto the lines.

All interrupt outputs are registered. Slots below 25 use a fixed default mapping. Slot 30 is hard-wired. Slots 25 to 29 and 31 are programmable.

Top module: `pirq_router`

## Requirements
- R1: After reset every routing byte (addresses 0 to 7) reads 0x80, the SCI control byte (address 8) reads 0x00, the SCI target is pin 9, and all legacy and APIC outputs are low.
- R2: A routing byte has the disable flag in bit 7 and the pin number in bits 4:0. Line n uses address n: lines 0 to 3 form the first bank and lines 4 to 7 the second. A line whose disable flag is set drives no legacy pin.
- R3: Each legacy output p is the OR of every enabled, asserted line whose pin field equals p. Lines that share a pin combine.
- R4: An enabled line whose pin field is 16 or more drives no legacy output.
- R5: APIC output n follows line n on every cycle, independent of that line's routing byte. It is also ORed with SCI when the SCI target is 16+n.
- R6: Bits 2:0 of the SCI control byte select the target: 0 selects 9, 1 selects 10, 2 selects 11, 4 selects 20 and 5 selects 21. A target below 16 is legacy pin t, and a target of 16 or more is APIC output t-16. The SCI level is ORed into that output, and it merges with any lines that are routed to the same pin.
- R7: Writing one of the reserved codes 3, 6 or 7 leaves the SCI target unchanged.
- R8: If SCI is held high while its target changes, then in one output update the old target drops and the new target rises.
- R9: Outputs register line and SCI inputs at the clock edge that samples them. A register write at edge k changes the outputs from edge k+1 on. At edge k itself, the outputs use the old configuration.
- R10: After reset, slot s pin i maps to line ((s+i) mod 4)+4. Slots 0 to 24 keep this mapping permanently.
- R11: Slot 30 pin i always maps to line 4+i. Its two register bytes (addresses 26 and 27) read 0, and writes to them are ignored.
- R12: Slots 25 to 29 and 31 each hold a 16-bit field: the low byte at address 16+2(s-25) and the high byte at the next address. Pin i takes its line from bits 4i+2 to 4i, and bit 4i+3 is stored but ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte address for both write and read |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| line_req | input | 8 | Shared interrupt line levels, line n on bit n |
| sci_req | input | 1 | SCI request level |
| map_slot | input | 5 | Slot number for the mapping lookup |
| map_pin | input | 2 | Pin (0 = INTA to 3 = INTD) for the lookup |
| map_line | output | 3 | Line that the queried slot pin uses |
| legacy_irq | output | 16 | Registered legacy interrupt pin levels |
| apic_irq | output | 8 | Registered APIC input levels (line n on bit n) |

## Verification
The two functions that can collide in one cycle are a configuration write and a change on the interrupt inputs. The bench provokes this in two ways. First, it writes a routing byte in the same cycle that it toggles the line that byte controls. Second, it rewrites the SCI select while SCI is held high. In the update taken at the write edge, the scoreboard expects the old routing, or the old SCI target, applied to the new inputs. In the following update it expects the new routing alone. For the SCI case, that means the old target has dropped and only the new one is high.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

   localparam int unsigned PIN_W  = 5;
   localparam int unsigned TGT_W  = 5;
   localparam int unsigned LINE_W = 3;

   typedef struct packed {
      logic             dis;
      logic [1:0]       spare;
      logic [PIN_W-1:0] pin;
   } route_t;

   localparam route_t ROUTE_RESET = '{dis: 1'b1, spare: 2'b00, pin: '0};
   localparam logic [TGT_W-1:0] SCI_RESET_TGT = TGT_W'(9);

   typedef struct packed {
      logic             valid;
      logic [TGT_W-1:0] tgt;
   } sci_sel_t;

   function automatic sci_sel_t sci_decode(input logic [2:0] code);
      sci_sel_t r;
      r.valid = 1'b1;
      case (code)
         3'd0:    r.tgt = TGT_W'(9);
         3'd1:    r.tgt = TGT_W'(10);
         3'd2:    r.tgt = TGT_W'(11);
         3'd4:    r.tgt = TGT_W'(20);
         3'd5:    r.tgt = TGT_W'(21);
         default: begin
            r.valid = 1'b0;
            r.tgt   = '0;
         end
      endcase
      return r;
   endfunction

   function automatic logic [LINE_W-1:0] default_line(input int slot, input int pin);
      return LINE_W'(((slot + pin) % 4) + 4);
   endfunction

   function automatic logic [15:0] slot_reset_map(input int slot);
      logic [15:0] m;
      m = '0;
      for (int i = 0; i < 4; i++) begin
         m[4*i +: 4] = {1'b0, default_line(slot, i)};
      end
      return m;
   endfunction

endpackage

// File: rtl/pirq_regs.sv
module pirq_regs
   import pirq_pkg::*;
#(
   parameter int unsigned LINES      = 8,
   parameter int unsigned ADDR_W     = 5,
   parameter int unsigned CTRL_ADDR  = 8,
   parameter int unsigned MAP_BASE   = 16,
   parameter int unsigned FIRST_SLOT = 25,
   parameter int unsigned PROG_SLOTS = 7,
   parameter int unsigned FIXED_SLOT = 30
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            wr_en,
   input  logic [ADDR_W-1:0]               addr,
   input  logic [7:0]                      wr_data,
   output logic [7:0]                      rd_data,
   output logic [LINES-1:0]                route_dis,
   output logic [LINES-1:0][PIN_W-1:0]     route_pin,
   output logic [TGT_W-1:0]                sci_tgt,
   output logic [PROG_SLOTS-1:0][15:0]     slot_map
);

   localparam int unsigned FIXED_IDX = FIXED_SLOT - FIRST_SLOT;

   if (LINES > CTRL_ADDR) begin : g_bad_ctrl
      $error("routing bytes overlap the SCI control address");
   end
   if (CTRL_ADDR >= MAP_BASE || MAP_BASE + 2*PROG_SLOTS > (1 << ADDR_W)) begin : g_bad_map
      $error("slot map window does not fit the address space");
   end
   if (FIXED_SLOT < FIRST_SLOT || FIXED_IDX >= PROG_SLOTS) begin : g_bad_fixed
      $error("fixed slot must lie inside the slot map window");
   end

   route_t [LINES-1:0]       route_q;
   logic   [7:0]             ctrl_q;
   logic   [TGT_W-1:0]       tgt_q;
   logic   [PROG_SLOTS-1:0][15:0] map_q;
   sci_sel_t                 dec;
   logic                     ctrl_hit;

   assign dec      = sci_decode(wr_data[2:0]);
   assign ctrl_hit = wr_en && (addr == ADDR_W'(CTRL_ADDR));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int n = 0; n < LINES; n++) route_q[n] <= ROUTE_RESET;
         ctrl_q <= '0;
         tgt_q  <= SCI_RESET_TGT;
         for (int k = 0; k < PROG_SLOTS; k++) begin
            map_q[k] <= (k == FIXED_IDX) ? 16'h0000 : slot_reset_map(FIRST_SLOT + k);
         end
      end else if (wr_en) begin
         for (int n = 0; n < LINES; n++) begin
            if (addr == ADDR_W'(n)) route_q[n] <= route_t'(wr_data);
         end
         if (ctrl_hit) begin
            ctrl_q <= wr_data;
            if (dec.valid) tgt_q <= dec.tgt;
         end
         for (int k = 0; k < PROG_SLOTS; k++) begin
            if (k != FIXED_IDX) begin
               if (addr == ADDR_W'(MAP_BASE + 2*k))     map_q[k][7:0]  <= wr_data;
               if (addr == ADDR_W'(MAP_BASE + 2*k + 1)) map_q[k][15:8] <= wr_data;
            end
         end
      end
   end

   always_comb begin
      rd_data = '0;
      for (int n = 0; n < LINES; n++) begin
         if (addr == ADDR_W'(n)) rd_data = route_q[n];
      end
      if (addr == ADDR_W'(CTRL_ADDR)) rd_data = ctrl_q;
      for (int k = 0; k < PROG_SLOTS; k++) begin
         if (addr == ADDR_W'(MAP_BASE + 2*k))     rd_data = map_q[k][7:0];
         if (addr == ADDR_W'(MAP_BASE + 2*k + 1)) rd_data = map_q[k][15:8];
      end
   end

   for (genvar n = 0; n < LINES; n++) begin : g_route_out
      assign route_dis[n] = route_q[n].dis;
      assign route_pin[n] = route_q[n].pin;
   end
   assign sci_tgt  = tgt_q;
   assign slot_map = map_q;

   // R6: the SCI target only ever holds one of the five legal encodings
   assert_sci_tgt_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_q inside {TGT_W'(9), TGT_W'(10), TGT_W'(11), TGT_W'(20), TGT_W'(21)});

   // R7: a reserved select code leaves the target where it was
   assert_reserved_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_hit && !dec.valid) |=> $stable(tgt_q));

endmodule

// File: rtl/pirq_slot_map.sv
module pirq_slot_map
   import pirq_pkg::*;
#(
   parameter int unsigned SLOT_W     = 5,
   parameter int unsigned FIRST_SLOT = 25,
   parameter int unsigned PROG_SLOTS = 7,
   parameter int unsigned FIXED_SLOT = 30
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [SLOT_W-1:0]           slot,
   input  logic [1:0]                  pin,
   input  logic [PROG_SLOTS-1:0][15:0] slot_map,
   output logic [LINE_W-1:0]           line
);

   localparam int unsigned FIXED_IDX = FIXED_SLOT - FIRST_SLOT;

   logic unused_map_bits;
   assign unused_map_bits = ^slot_map;

   always_comb begin
      line = default_line(int'(slot), int'(pin));
      for (int k = 0; k < PROG_SLOTS; k++) begin
         if (k != FIXED_IDX && slot == SLOT_W'(FIRST_SLOT + k)) begin
            line = slot_map[k][{pin, 2'b00} +: LINE_W];
         end
      end
      if (slot == SLOT_W'(FIXED_SLOT)) line = {1'b1, pin};
   end

   // R10: non-programmable slots never land on lines 0 to 3
   assert_default_upper_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (slot < SLOT_W'(FIRST_SLOT)) |-> line[2]);

endmodule

// File: rtl/pirq_combine.sv
module pirq_combine
   import pirq_pkg::*;
#(
   parameter int unsigned LINES       = 8,
   parameter int unsigned LEGACY_PINS = 16
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [LINES-1:0]            line_req,
   input  logic                        sci_req,
   input  logic [LINES-1:0]            route_dis,
   input  logic [LINES-1:0][PIN_W-1:0] route_pin,
   input  logic [TGT_W-1:0]            sci_tgt,
   output logic [LEGACY_PINS-1:0]      legacy_q,
   output logic [LINES-1:0]            apic_q
);

   logic [LEGACY_PINS-1:0] leg_d;
   logic [LINES-1:0]       apic_d;

   always_comb begin
      leg_d = '0;
      for (int p = 0; p < LEGACY_PINS; p++) begin
         for (int n = 0; n < LINES; n++) begin
            if (line_req[n] && !route_dis[n] && route_pin[n] == PIN_W'(p)) leg_d[p] = 1'b1;
         end
         if (sci_req && sci_tgt == TGT_W'(p)) leg_d[p] = 1'b1;
      end
   end

   for (genvar n = 0; n < LINES; n++) begin : g_apic
      assign apic_d[n] = line_req[n] | (sci_req && sci_tgt == TGT_W'(LEGACY_PINS + n));

      // R5: an asserted line always reaches its own APIC output next cycle
      assert_apic_follows_line_R5: assert property (@(posedge clk) disable iff (!rst_n)
         line_req[n] |=> apic_q[n]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         legacy_q <= '0;
         apic_q   <= '0;
      end else begin
         legacy_q <= leg_d;
         apic_q   <= apic_d;
      end
   end

   // R2: with every line disabled and SCI idle the legacy pins stay quiet
   assert_disabled_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!sci_req && (&route_dis)) |=> legacy_q == '0);

   // R6: a raised SCI always lights some output
   assert_sci_visible_R6: assert property (@(posedge clk) disable iff (!rst_n)
      sci_req |=> (legacy_q != '0 || apic_q != '0));

   // R8: a target move under a held SCI leaves exactly one output high
   assert_sci_handoff_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (sci_req && !$stable(sci_tgt) && line_req == '0) |=> $countones({legacy_q, apic_q}) == 1);

endmodule

// File: rtl/pirq_router.sv
module pirq_router
   import pirq_pkg::*;
#(
   parameter int unsigned LINES       = 8,
   parameter int unsigned LEGACY_PINS = 16,
   parameter int unsigned ADDR_W      = 5,
   parameter int unsigned SLOT_W      = 5,
   parameter int unsigned FIRST_SLOT  = 25,
   parameter int unsigned PROG_SLOTS  = 7,
   parameter int unsigned FIXED_SLOT  = 30
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   reg_we,
   input  logic [ADDR_W-1:0]      reg_addr,
   input  logic [7:0]             reg_wdata,
   output logic [7:0]             reg_rdata,
   input  logic [LINES-1:0]       line_req,
   input  logic                   sci_req,
   input  logic [SLOT_W-1:0]      map_slot,
   input  logic [1:0]             map_pin,
   output logic [LINE_W-1:0]      map_line,
   output logic [LEGACY_PINS-1:0] legacy_irq,
   output logic [LINES-1:0]       apic_irq
);

   localparam int unsigned CTRL_ADDR = 8;
   localparam int unsigned MAP_BASE  = 16;

   if (LINES != 8) begin : g_bad_lines
      $error("router needs exactly two banks of four lines");
   end
   if (LEGACY_PINS <= 11 || LEGACY_PINS > 20 || LEGACY_PINS + LINES <= 21
       || LEGACY_PINS + LINES > (1 << PIN_W)) begin : g_bad_pins
      $error("legacy pin count does not cover the SCI targets");
   end
   if (FIRST_SLOT + PROG_SLOTS > (1 << SLOT_W)) begin : g_bad_slots
      $error("slot window exceeds the slot number width");
   end

   logic [LINES-1:0]            route_dis;
   logic [LINES-1:0][PIN_W-1:0] route_pin;
   logic [TGT_W-1:0]            sci_tgt;
   logic [PROG_SLOTS-1:0][15:0] slot_map;

   pirq_regs #(
      .LINES(LINES), .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .MAP_BASE(MAP_BASE),
      .FIRST_SLOT(FIRST_SLOT), .PROG_SLOTS(PROG_SLOTS), .FIXED_SLOT(FIXED_SLOT)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .addr(reg_addr), .wr_data(reg_wdata),
      .rd_data(reg_rdata), .route_dis(route_dis), .route_pin(route_pin),
      .sci_tgt(sci_tgt), .slot_map(slot_map)
   );

   pirq_slot_map #(
      .SLOT_W(SLOT_W), .FIRST_SLOT(FIRST_SLOT), .PROG_SLOTS(PROG_SLOTS), .FIXED_SLOT(FIXED_SLOT)
   ) u_map (
      .clk(clk), .rst_n(rst_n), .slot(map_slot), .pin(map_pin),
      .slot_map(slot_map), .line(map_line)
   );

   pirq_combine #(
      .LINES(LINES), .LEGACY_PINS(LEGACY_PINS)
   ) u_comb (
      .clk(clk), .rst_n(rst_n), .line_req(line_req), .sci_req(sci_req),
      .route_dis(route_dis), .route_pin(route_pin), .sci_tgt(sci_tgt),
      .legacy_q(legacy_irq), .apic_q(apic_irq)
   );

endmodule

// File: tb/pirq_router_tb.sv
`timescale 1ns/1ps
module pirq_router_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [4:0]  reg_addr = '0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic [7:0]  line_req = '0;
   logic        sci_req = 1'b0;
   logic [4:0]  map_slot = '0;
   logic [1:0]  map_pin = '0;
   logic [2:0]  map_line;
   logic [15:0] legacy_irq;
   logic [7:0]  apic_irq;

   always #4 clk = ~clk;

   pirq_router u_dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .line_req(line_req),
      .sci_req(sci_req), .map_slot(map_slot), .map_pin(map_pin),
      .map_line(map_line), .legacy_irq(legacy_irq), .apic_irq(apic_irq)
   );

   int n_cmp = 0;
   int n_bad = 0;
   int cyc = 0;
   bit done = 1'b0;

   typedef struct {
      int          due;
      logic [23:0] outs;
      string       tag;
   } exp_t;
   exp_t sb[$];

   logic [7:0] m_rout [8];
   int         m_tgt = 9;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [23:0] model(input logic [7:0] ln, input logic s);
      logic [15:0] leg;
      logic [7:0]  ap;
      leg = '0;
      ap  = ln;
      for (int n = 0; n < 8; n++) begin
         if (ln[n] && !m_rout[n][7] && m_rout[n][4:0] < 5'd16) leg[m_rout[n][3:0]] = 1'b1;
      end
      if (s) begin
         if (m_tgt < 16) leg[m_tgt] = 1'b1;
         else if (m_tgt < 24) ap[m_tgt-16] = 1'b1;
      end
      return {ap, leg};
   endfunction

   function automatic void model_write(input logic [4:0] a, input logic [7:0] d);
      if (a < 5'd8) m_rout[a[2:0]] = d;
      else if (a == 5'd8) begin
         case (d[2:0])
            3'd0: m_tgt = 9;
            3'd1: m_tgt = 10;
            3'd2: m_tgt = 11;
            3'd4: m_tgt = 20;
            3'd5: m_tgt = 21;
            default: ;
         endcase
      end
   endfunction

   // scoreboard monitor: compares queued expectations when due
   always @(negedge clk) begin : mon
      exp_t e;
      while (sb.size() != 0 && sb[0].due <= cyc) begin
         e = sb.pop_front();
         chk({8'h0, apic_irq, legacy_irq}, {8'h0, e.outs}, e.tag);
      end
   end

   task automatic push(input logic [7:0] ln, input logic s, input string tag);
      exp_t e;
      e.due  = cyc + 1;
      e.outs = model(ln, s);
      e.tag  = tag;
      sb.push_back(e);
   endtask

   task automatic step(input logic [7:0] ln, input logic s, input string tag);
      line_req = ln;
      sci_req  = s;
      push(ln, s, tag);
      @(negedge clk);
   endtask

   task automatic wr(input logic [4:0] a, input logic [7:0] d);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
      void'(model_write(a, d));
   endtask

   // write and input change in the same cycle: old config seen at that edge
   task automatic wr_step(input logic [4:0] a, input logic [7:0] d,
                          input logic [7:0] ln, input logic s, input string tag);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      line_req = ln; sci_req = s;
      push(ln, s, tag);
      @(negedge clk);
      reg_we = 1'b0;
      void'(model_write(a, d));
   endtask

   task automatic rd(input logic [4:0] a, input logic [7:0] exp, input string tag);
      reg_addr = a;
      #1;
      chk({24'h0, reg_rdata}, {24'h0, exp}, tag);
   endtask

   task automatic lookup(input int s, input int p, input int exp, input string tag);
      map_slot = 5'(s);
      map_pin  = 2'(p);
      #1;
      chk({29'h0, map_line}, 32'(exp), tag);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      for (int n = 0; n < 8; n++) m_rout[n] = 8'h80;
      repeat (3) @(negedge clk);
      chk({8'h0, apic_irq, legacy_irq}, 32'h0, "R1 outputs in reset");
      rst_n = 1'b1;
      @(negedge clk);
      chk({8'h0, apic_irq, legacy_irq}, 32'h0, "R1 outputs after reset");
      for (int a = 0; a < 8; a++) rd(5'(a), 8'h80, "R1 routing byte reset");
      rd(5'd8, 8'h00, "R1 SCI control reset");

      // R10 defaults, R11 fixed slot, R12 default field layout
      lookup(0, 0, 4, "R10 slot0 pinA");
      lookup(3, 1, 4, "R10 slot3 pinB");
      lookup(10, 3, 5, "R10 slot10 pinD");
      for (int i = 0; i < 4; i++) lookup(25, i, ((25 + i) % 4) + 4, "R10 slot25");
      for (int i = 0; i < 4; i++) lookup(31, i, ((31 + i) % 4) + 4, "R10 slot31");
      for (int i = 0; i < 4; i++) lookup(30, i, 4 + i, "R11 slot30");
      rd(5'd16, 8'h65, "R12 slot25 low byte");
      rd(5'd17, 8'h47, "R12 slot25 high byte");
      rd(5'd28, 8'h47, "R12 slot31 low byte");
      rd(5'd26, 8'h00, "R11 slot30 low reads zero");
      @(negedge clk);

      // R2/R5: all lines disabled
      step(8'hFF, 1'b0, "R2 R5 disabled lines only reach APIC");
      step(8'h00, 1'b0, "R5 idle");

      // R3 sharing
      wr(5'd0, 8'h05); wr(5'd1, 8'h05); wr(5'd4, 8'h0B); wr(5'd7, 8'h03);
      step(8'h01, 1'b0, "R3 line0 to pin5");
      step(8'h03, 1'b0, "R3 lines0,1 share pin5");
      step(8'h02, 1'b0, "R3 line1 alone");
      step(8'h10, 1'b0, "R3 line4 bank two to pin11");
      step(8'h91, 1'b0, "R3 mixed banks");
      step(8'h80, 1'b0, "R3 line7 to pin3");

      // R4 out of range pins
      wr(5'd2, 8'h10); wr(5'd3, 8'h1F);
      step(8'h0C, 1'b0, "R4 pin field 16 and 31");
      // R2 disable flag keeps pin field
      wr(5'd0, 8'h85);
      step(8'h01, 1'b0, "R2 disabled line0");
      step(8'h00, 1'b0, "R2 idle");

      // R6 SCI targets
      step(8'h00, 1'b1, "R6 default target 9");
      wr(5'd8, 8'h01); step(8'h00, 1'b1, "R6 code1 target 10");
      wr(5'd8, 8'h04); step(8'h00, 1'b1, "R6 code4 target APIC 20");
      wr(5'd8, 8'h05); step(8'h20, 1'b1, "R6 R5 code5 APIC 21 merged with line5");
      wr(5'd8, 8'h02); step(8'h00, 1'b1, "R6 code2 target 11");
      wr(5'd8, 8'h03); step(8'h00, 1'b1, "R7 code3 keeps 11");
      wr(5'd8, 8'h07); step(8'h00, 1'b1, "R7 code7 keeps 11");
      wr(5'd8, 8'h06); step(8'h00, 1'b1, "R7 code6 keeps 11");

      // R8/R9 target change under held SCI
      wr_step(5'd8, 8'h00, 8'h00, 1'b1, "R9 old SCI target at write edge");
      step(8'h00, 1'b1, "R8 handoff to pin9 only");
      wr_step(5'd8, 8'h04, 8'h00, 1'b1, "R9 still pin9 at write edge");
      step(8'h00, 1'b1, "R8 handoff to APIC 20 only");
      wr(5'd8, 8'h00);
      step(8'h00, 1'b0, "R6 SCI low");

      // R9 routing write alongside line toggle
      wr_step(5'd1, 8'h07, 8'h02, 1'b0, "R9 old routing at write edge");
      step(8'h02, 1'b0, "R9 R3 new routing pin7");

      // R6 merge with a line on the SCI pin
      wr(5'd5, 8'h09);
      step(8'h20, 1'b1, "R6 line5 and SCI share pin9");
      step(8'h20, 1'b0, "R6 line5 alone on pin9");
      step(8'h00, 1'b0, "R3 idle");

      // R12 programming, R11 ignored writes
      wr(5'd20, 8'h21); wr(5'd21, 8'hB3);
      lookup(27, 0, 1, "R12 slot27 pinA");
      lookup(27, 1, 2, "R12 slot27 pinB");
      lookup(27, 2, 3, "R12 slot27 pinC");
      lookup(27, 3, 3, "R12 slot27 pinD ignores bit 15");
      rd(5'd21, 8'hB3, "R12 slot27 high readback");
      wr(5'd26, 8'hFF); wr(5'd27, 8'hFF);
      rd(5'd26, 8'h00, "R11 slot30 low after write");
      rd(5'd27, 8'h00, "R11 slot30 high after write");
      lookup(30, 0, 4, "R11 slot30 pinA after write");
      lookup(30, 3, 7, "R11 slot30 pinD after write");
      lookup(26, 0, ((26) % 4) + 4, "R10 slot26 untouched");

      repeat (3) @(negedge clk);
      if (sb.size() != 0) begin
         n_bad++;
         $display("FAIL scoreboard: actual %0d pending expected 0", sb.size());
      end
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

endmodule